// File: doc/BRIEF.md
# Thermometer Shift Controller for a Digital Linear Regulator

This block is the digital control core of a discrete-time linear voltage regulator. On every rising edge of the sample clock it takes a 3-bit thermometer-coded error word from a clocked comparator bank. It turns that word into a shift direction and a step size. It then moves a wide thermometer register that drives the active-low gates of a bank of pull-up devices. The register acts as a discrete-time integrator of the error. Small errors move it by one position. Large errors move it by a step set through a 2-bit gain input.

The register changes its value through two cascaded multiplexer levels in every stage. The first level moves by two positions, and the second moves by one. Steps of 0, 1, 2 or 3 positions therefore complete in a single cycle. Both ends saturate, so the pattern always stays a clean thermometer. Enabled devices are zeros packed from bit 0 upward, and disabled devices are ones above them. A count of the enabled devices is also brought out for observation.

Top module: `gate_shift_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the register loads `INIT_ON` enabled devices. Bits 0..INIT_ON-1 of `gateWord` are 0 and the rest are 1. Reset takes priority over any error code.
- R2: Error code 3'b001 (one comparator tripped, output slightly low) raises the enabled count by exactly 1.
- R3: Error code 3'b011 (output slightly high) lowers the enabled count by exactly 1.
- R4: Error code 3'b000 (output far below target) raises the enabled count by the gain step.
- R5: Error code 3'b111 (output far above target) lowers the enabled count by the gain step.
- R6: The gain step follows `gainSel`: 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 3, and 2'b00 gives 1. The gain input has no effect on codes 3'b001 and 3'b011.
- R7: Codes that are not thermometer codes (3'b010, 3'b100, 3'b101, 3'b110) leave `gateWord` and `enabledCount` unchanged for that cycle.
- R8: A move that would pass either end saturates. The enabled count is clamped to 0..WIDTH.
- R9: `gateWord` is always a thermometer word: a run of zeros starting at bit 0, with ones above it. `enabledCount` equals the number of zeros.
- R10: The code and gain present at a rising edge take effect in `gateWord` and `enabledCount` right after that same edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; code sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| errCode | input | 3 | Thermometer error word from the comparators |
| gainSel | input | 2 | Step size used for large errors |
| gateWord | output | WIDTH (128) | Active-low pull-up gate enables |
| enabledCount | output | $clog2(WIDTH+1) (8) | Number of enabled devices |

## Verification
The bench builds the block with its default values: a 128-position register with 64 devices enabled at reset. With those values the maximum step of 3 reaches the upper end from reset in 22 cycles and the lower end in about 43 more. Both saturation walls are therefore exercised, including the partial step that would overshoot them. A long random run of codes and gains is checked every cycle against an integer model that clamps to 0..128. That run covers the invalid codes falling between valid moves and shows that the word stays a thermometer at every count.

// File: rtl/gshift_pkg.sv
package gshift_pkg;

  // Thermometer error codes from the comparator bank (bit 2 is the highest threshold)
  localparam logic [2:0] CODE_FAR_LOW   = 3'b000;
  localparam logic [2:0] CODE_NEAR_LOW  = 3'b001;
  localparam logic [2:0] CODE_NEAR_HIGH = 3'b011;
  localparam logic [2:0] CODE_FAR_HIGH  = 3'b111;

  // Strobes from the decoder to the shift datapath
  typedef struct packed {
    logic dirUp;   // 1: enable more devices, 0: disable devices
    logic useTwo;  // first mux level moves two positions
    logic useOne;  // second mux level moves one position
  } shift_strobe_t;

  function automatic logic [1:0] gainToStep(input logic [1:0] gainCode);
    logic [1:0] stepVal;
    case (gainCode)
      2'b10:   stepVal = 2'd2;
      2'b11:   stepVal = 2'd3;
      default: stepVal = 2'd1;
    endcase
    return stepVal;
  endfunction

endpackage

// File: rtl/gshift_decode.sv
module gshift_decode
  import gshift_pkg::*;
(
  input  logic [2:0]    errCode,
  input  logic [1:0]    gainSel,
  output shift_strobe_t strobe
);

  logic [1:0] gainStep;
  logic [1:0] moveMag;
  logic       moveUp;

  assign gainStep = gainToStep(gainSel);

  always_comb begin
    moveUp  = 1'b0;
    moveMag = 2'd0;
    case (errCode)
      CODE_FAR_LOW:   begin moveUp = 1'b1; moveMag = gainStep; end
      CODE_NEAR_LOW:  begin moveUp = 1'b1; moveMag = 2'd1;     end
      CODE_NEAR_HIGH: begin moveUp = 1'b0; moveMag = 2'd1;     end
      CODE_FAR_HIGH:  begin moveUp = 1'b0; moveMag = gainStep; end
      default:        begin moveUp = 1'b0; moveMag = 2'd0;     end
    endcase
  end

  assign strobe.dirUp  = moveUp;
  assign strobe.useTwo = moveMag[1];
  assign strobe.useOne = moveMag[0];

endmodule

// File: rtl/gshift_datapath.sv
module gshift_datapath
  import gshift_pkg::*;
#(
  parameter int WIDTH   = 128,
  parameter int INIT_ON = 64
)(
  input  logic             clk,
  input  logic             rst,
  input  shift_strobe_t    strobe,
  output logic [WIDTH-1:0] gateWord
);

  localparam logic [WIDTH-1:0] ONE_W     = WIDTH'(1);
  localparam logic [WIDTH-1:0] INIT_WORD = ~((ONE_W << INIT_ON) - ONE_W);
  localparam logic [WIDTH-1:0] ALL_OFF   = '1;
  localparam logic [WIDTH-1:0] ALL_ON    = '0;

  logic [WIDTH-1:0] gateQ;
  logic [WIDTH+3:0] aExt;   // register padded: two enabled below, two disabled above
  logic [WIDTH-1:0] lvlTwo;
  logic [WIDTH+1:0] bExt;   // first level padded by one on each side
  logic [WIDTH-1:0] lvlOne;

  assign aExt = {2'b11, gateQ, 2'b00};
  assign bExt = {1'b1, lvlTwo, 1'b0};

  for (genvar n = 0; n < WIDTH; n++) begin : g_stage
    // level 1: neighbour n, n-2 (moving up) or n+2 (moving down)
    assign lvlTwo[n] = strobe.useTwo ? (strobe.dirUp ? aExt[n] : aExt[n+4]) : aExt[n+2];
    // level 2: neighbour n, n-1 (moving up) or n+1 (moving down)
    assign lvlOne[n] = strobe.useOne ? (strobe.dirUp ? bExt[n] : bExt[n+2]) : bExt[n+1];
  end

  always_ff @(posedge clk) begin
    if (rst) gateQ <= INIT_WORD;
    else     gateQ <= lvlOne;
  end

  assign gateWord = gateQ;

  // R9: zeros packed from bit 0, ones above
  a_r9_thermometer: assert property (@(posedge clk) disable iff (rst)
    (((~gateQ) & ((~gateQ) + ONE_W)) == ALL_ON));

  // R8: full bank stays full when moving up, empty bank stays empty when not moving up
  a_r8_top_wall: assert property (@(posedge clk) disable iff (rst)
    (gateQ == ALL_ON && strobe.dirUp) |=> (gateQ == ALL_ON));
  a_r8_bottom_wall: assert property (@(posedge clk) disable iff (rst)
    (gateQ == ALL_OFF && !strobe.dirUp) |=> (gateQ == ALL_OFF));

endmodule

// File: rtl/gshift_count.sv
module gshift_count #(
  parameter int WIDTH = 128,
  parameter int CNT_W = $clog2(WIDTH + 1)
)(
  input  logic [WIDTH-1:0] gateWord,
  output logic [CNT_W-1:0] enabledCount
);

  always_comb begin
    enabledCount = '0;
    for (int i = 0; i < WIDTH; i++) begin
      enabledCount = enabledCount + CNT_W'(!gateWord[i]);
    end
  end

endmodule

// File: rtl/gate_shift_ctrl.sv
module gate_shift_ctrl
  import gshift_pkg::*;
#(
  parameter int WIDTH   = 128,
  parameter int INIT_ON = 64,
  localparam int CNT_W  = $clog2(WIDTH + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       errCode,
  input  logic [1:0]       gainSel,
  output logic [WIDTH-1:0] gateWord,
  output logic [CNT_W-1:0] enabledCount
);

  shift_strobe_t strobe;

  gshift_decode i_decode (
    .errCode (errCode),
    .gainSel (gainSel),
    .strobe  (strobe)
  );

  gshift_datapath #(.WIDTH(WIDTH), .INIT_ON(INIT_ON)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .gateWord (gateWord)
  );

  gshift_count #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_count (
    .gateWord     (gateWord),
    .enabledCount (enabledCount)
  );

  // R7: non-thermometer codes hold the register
  a_r7_invalid_hold: assert property (@(posedge clk) disable iff (rst)
    (errCode == 3'b010 || errCode == 3'b100 || errCode == 3'b101 || errCode == 3'b110)
    |=> $stable(gateWord));

  // R2: small low error adds one device
  a_r2_single_up: assert property (@(posedge clk) disable iff (rst)
    (errCode == 3'b001 && enabledCount < CNT_W'(WIDTH))
    |=> (enabledCount == $past(enabledCount) + CNT_W'(1)));

  // R3: small high error removes one device
  a_r3_single_down: assert property (@(posedge clk) disable iff (rst)
    (errCode == 3'b011 && enabledCount > CNT_W'(0))
    |=> (enabledCount == $past(enabledCount) - CNT_W'(1)));

  // R4, R6: far low error with gain 3 adds three devices away from the wall
  a_r4_gain_up: assert property (@(posedge clk) disable iff (rst)
    (errCode == 3'b000 && gainSel == 2'b11 && enabledCount <= CNT_W'(WIDTH - 3))
    |=> (enabledCount == $past(enabledCount) + CNT_W'(3)));

  // R5, R6: far high error with gain 2 removes two devices away from the wall
  a_r5_gain_down: assert property (@(posedge clk) disable iff (rst)
    (errCode == 3'b111 && gainSel == 2'b10 && enabledCount >= CNT_W'(2))
    |=> (enabledCount == $past(enabledCount) - CNT_W'(2)));

endmodule

// File: tb/test_gate_shift_ctrl.sv
`timescale 1ns/1ps
module test_gate_shift_ctrl;

  localparam int WIDTH   = 128;
  localparam int INIT_ON = 64;
  localparam int CNT_W   = $clog2(WIDTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       errCode = 3'b010;
  logic [1:0]       gainSel = 2'b00;
  logic [WIDTH-1:0] gateWord;
  logic [CNT_W-1:0] enabledCount;

  int  nChecks = 0;
  int  nErrors = 0;
  int  model   = INIT_ON;
  int  cycles  = 0;
  bit  done    = 0;

  always #2.5 clk = ~clk;

  gate_shift_ctrl #(.WIDTH(WIDTH), .INIT_ON(INIT_ON)) i_gate_shift_ctrl (
    .clk          (clk),
    .rst          (rst),
    .errCode      (errCode),
    .gainSel      (gainSel),
    .gateWord     (gateWord),
    .enabledCount (enabledCount)
  );

  function automatic logic [WIDTH-1:0] thermoWord(input int cnt);
    logic [WIDTH-1:0] w;
    for (int i = 0; i < WIDTH; i++) w[i] = (i >= cnt);
    return w;
  endfunction

  function automatic int stepOf(input logic [1:0] g);
    return (g == 2'b10) ? 2 : (g == 2'b11) ? 3 : 1;
  endfunction

  function automatic int clampCnt(input int v);
    return (v < 0) ? 0 : (v > WIDTH) ? WIDTH : v;
  endfunction

  task automatic checkState(input string req);
    logic [WIDTH-1:0] expWord;
    expWord = thermoWord(model);
    nChecks++;
    if (int'(enabledCount) != model) begin
      nErrors++;
      $display("FAIL %s count actual=%0d expected=%0d", req, enabledCount, model);
    end
    nChecks++;
    if (gateWord !== expWord) begin
      nErrors++;
      $display("FAIL %s gateWord actual=%h expected=%h", req, gateWord, expWord);
    end
  endtask

  // drive at a falling edge, let one rising edge act, sample at the next falling edge (R10)
  task automatic applyCode(input logic [2:0] code, input logic [1:0] gain, input string req);
    errCode = code;
    gainSel = gain;
    @(posedge clk);
    @(negedge clk);
    case (code)
      3'b000:  model = clampCnt(model + stepOf(gain));
      3'b001:  model = clampCnt(model + 1);
      3'b011:  model = clampCnt(model - 1);
      3'b111:  model = clampCnt(model - stepOf(gain));
      default: model = model;
    endcase
    checkState(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    errCode = 3'b000;
    gainSel = 2'b11;
    repeat (3) @(negedge clk);
    model = INIT_ON;
    checkState("R1 reset value under active code");
    rst = 1'b0;
  endtask

  task automatic t_single();
    applyCode(3'b001, 2'b11, "R2 near-low up one, gain ignored R6");
    applyCode(3'b001, 2'b00, "R2 near-low up one");
    applyCode(3'b011, 2'b10, "R3 near-high down one, gain ignored R6");
    applyCode(3'b011, 2'b01, "R3 near-high down one");
  endtask

  task automatic t_gain();
    for (int g = 0; g < 4; g++) begin
      applyCode(3'b000, 2'(g), "R4 R6 far-low up by gain");
      applyCode(3'b111, 2'(g), "R5 R6 far-high down by gain");
    end
  endtask

  task automatic t_invalid();
    logic [2:0] bad [4] = '{3'b010, 3'b100, 3'b101, 3'b110};
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < 4; g++) applyCode(bad[k], 2'(g), "R7 invalid code holds");
    end
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 25; k++) applyCode(3'b000, 2'b11, "R8 climb to top wall");
    applyCode(3'b001, 2'b00, "R8 top wall near-low holds");
    applyCode(3'b000, 2'b10, "R8 top wall far-low holds");
    applyCode(3'b011, 2'b00, "R3 step off top wall");
    applyCode(3'b000, 2'b11, "R8 partial step clamps at top");
    for (int k = 0; k < 45; k++) applyCode(3'b111, 2'b11, "R8 descend to bottom wall");
    applyCode(3'b011, 2'b00, "R8 bottom wall near-high holds");
    applyCode(3'b111, 2'b10, "R8 bottom wall far-high holds");
    applyCode(3'b001, 2'b00, "R2 step off bottom wall");
    applyCode(3'b111, 2'b11, "R8 partial step clamps at bottom");
  endtask

  task automatic t_random();
    for (int k = 0; k < 600; k++) begin
      applyCode(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R9 R10 random sequence");
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d cycles", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_gain();
    t_invalid();
    t_saturate();
    t_reset();
    t_random();
    done = 1;
    finishRun();
  end

endmodule